// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of every data beat in one read or write burst of a double-data-rate SDRAM-style memory path. A one-cycle start pulse captures a starting column address and a small mode word that carries the burst-length code and the burst-type bit. From the capturing edge on, the block presents one column address per clock with a valid flag, and it raises a last flag on the final beat.

Only the low column bits inside the aligned block of 2, 4 or 8 columns move. Bits above that block keep the value of the starting address for the whole burst. In sequential order the low bits count up and wrap inside the block. In interleaved order, beat k uses the starting low bits XOR k. A burst-length code with no defined length starts nothing and produces a one-cycle error pulse.

Top module: `burst_col_seq`

## Requirements
- R1: A synchronous active-high `rst` clears the block. While it is held and in the cycle after it is released, `addr_valid`, `burst_last` and `len_err` are low.
- R2: `mode_word[2:0]` selects the burst length: 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats. `mode_word[3]` selects the order: 0 is sequential and 1 is interleaved.
- R3: A `start` sampled at a rising edge while the block is idle is accepted. Beat 0, which equals `start_col`, is visible after that same edge, and one further beat follows per clock with `addr_valid` high.
- R4: In sequential order the in-block low bits of beat k are (start low bits + k) modulo the burst length. For example, length 8 with start 5 gives 5-6-7-0-1-2-3-4.
- R5: In interleaved order the in-block low bits of beat k are the start low bits XOR k. For example, length 8 with start 6 gives 6-7-4-5-2-3-0-1.
- R6: Column bits at and above bit log2(length) hold the value of `start_col` on every beat of a burst, in both orders.
- R7: For length 2, both orders give the same sequence: start 0 gives 0-1 and start 1 gives 1-0.
- R8: `burst_last` is high on the final beat of each burst and on no other cycle. `addr_valid` drops after the final beat unless a new burst is accepted.
- R9: A `start` that arrives while a burst is active and the current beat is not the last one is ignored, and the running burst continues unchanged. A `start` sampled at the edge that ends the last beat is accepted, and its beat 0 follows with no idle cycle.
- R10: An accepted `start` whose length code is none of those in R2 issues no beats and sets `len_err` high for exactly the one cycle after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Burst request pulse |
| start_col | input | COL_W | Starting column address of the burst |
| mode_word | input | MODE_W | Mode word: bits 2:0 length code, bit 3 burst order |
| col_addr | output | COL_W | Column address of the current beat |
| addr_valid | output | 1 | `col_addr` holds a beat of an active burst |
| burst_last | output | 1 | Current beat is the final one of the burst |
| len_err | output | 1 | One-cycle pulse for a reserved length code |

## Verification
Several properties are checked on every clock: the last flag appears only on a valid beat, the high column bits stay fixed between consecutive beats, consecutive beats never repeat an address, a burst ends after its last beat unless a new start arrives, and the error pulse never coincides with a beat. The exact beat order for each length, start offset and burst type, the behaviour when a start is ignored part way through a burst, back-to-back acceptance at the last beat, and the absence of beats after a reserved code are shown only by the bench. Its scoreboard predicts every address from the requirements and compares each beat against that prediction.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   // widest in-block offset: bursts of up to 8 beats
   localparam int BLK_W = 3;

   typedef enum logic {
      ORD_SEQ   = 1'b0,
      ORD_INTLV = 1'b1
   } burst_order_e;

   // burst-length codes carried in mode_word[2:0]
   localparam logic [2:0] LEN_CODE_2 = 3'b001;
   localparam logic [2:0] LEN_CODE_4 = 3'b010;
   localparam logic [2:0] LEN_CODE_8 = 3'b011;

   // position of the order bit inside the mode word
   localparam int ORDER_BIT = 3;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
   import burst_seq_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic [CODE_W-1:0] len_code,
   output logic [BLK_W-1:0]  blk_mask,
   output logic              reserved
);

   if (CODE_W != 3) begin : g_bad_code
      $error("burst_len_decode: CODE_W must be 3");
   end

   always_comb begin
      blk_mask = '0;
      reserved = 1'b0;
      unique case (len_code)
         LEN_CODE_2: blk_mask = 3'b001;
         LEN_CODE_4: blk_mask = 3'b011;
         LEN_CODE_8: blk_mask = 3'b111;
         default:    reserved = 1'b1;
      endcase
   end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
   import burst_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [BLK_W-1:0] mask_in,
   input  logic             reserved,
   input  logic             order_in,
   output logic             load,
   output logic             active,
   output logic [BLK_W-1:0] beat,
   output logic [BLK_W-1:0] mask_q,
   output logic             order_q,
   output logic             last,
   output logic             err
);

   logic window;

   // the final beat counts as free so that bursts can run back to back
   assign last   = active && (beat == mask_q);
   assign window = !active || last;
   assign load   = start && window && !reserved;

   always_ff @(posedge clk) begin
      if (rst) begin
         active  <= 1'b0;
         beat    <= '0;
         mask_q  <= '0;
         order_q <= 1'b0;
         err     <= 1'b0;
      end else begin
         err <= start && window && reserved;
         if (load) begin
            active  <= 1'b1;
            beat    <= '0;
            mask_q  <= mask_in;
            order_q <= order_in;
         end else if (last) begin
            active <= 1'b0;
            beat   <= '0;
         end else if (active) begin
            beat <= beat + 1'b1;
         end
      end
   end

endmodule

// File: rtl/burst_low_gen.sv
module burst_low_gen
   import burst_seq_pkg::*;
(
   input  logic [BLK_W-1:0] start_low,
   input  logic [BLK_W-1:0] beat,
   input  logic [BLK_W-1:0] mask,
   input  logic             order,
   output logic [BLK_W-1:0] low_out
);

   logic [BLK_W-1:0] seq_sum;
   logic [BLK_W-1:0] xor_val;

   assign seq_sum = start_low + beat;
   assign xor_val = start_low ^ beat;

   // per bit: inside the block take the ordered value, outside keep the start
   for (genvar i = 0; i < BLK_W; i++) begin : g_bit
      always_comb begin
         if (!mask[i])
            low_out[i] = start_low[i];
         else if (order == ORD_INTLV)
            low_out[i] = xor_val[i];
         else
            low_out[i] = seq_sum[i];
      end
   end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import burst_seq_pkg::*;
#(
   parameter int COL_W  = 10,
   parameter int MODE_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [COL_W-1:0]  start_col,
   input  logic [MODE_W-1:0] mode_word,
   output logic [COL_W-1:0]  col_addr,
   output logic              addr_valid,
   output logic              burst_last,
   output logic              len_err
);

   localparam int HI_W = COL_W - BLK_W;

   if (COL_W < BLK_W) begin : g_bad_col
      $error("burst_col_seq: COL_W must be at least 3");
   end
   if (MODE_W <= ORDER_BIT) begin : g_bad_mode
      $error("burst_col_seq: MODE_W must cover the order bit");
   end

   logic [BLK_W-1:0] dec_mask;
   logic             dec_rsv;
   logic             load;
   logic             active;
   logic [BLK_W-1:0] beat;
   logic [BLK_W-1:0] mask_q;
   logic             order_q;
   logic             last;
   logic             err;
   logic [COL_W-1:0] col_q;
   logic [BLK_W-1:0] low_addr;

   burst_len_decode #(.CODE_W(3)) i_dec (
      .len_code (mode_word[2:0]),
      .blk_mask (dec_mask),
      .reserved (dec_rsv)
   );

   burst_beat_ctrl i_ctrl (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .mask_in  (dec_mask),
      .reserved (dec_rsv),
      .order_in (mode_word[ORDER_BIT]),
      .load     (load),
      .active   (active),
      .beat     (beat),
      .mask_q   (mask_q),
      .order_q  (order_q),
      .last     (last),
      .err      (err)
   );

   always_ff @(posedge clk) begin
      if (rst)
         col_q <= '0;
      else if (load)
         col_q <= start_col;
   end

   burst_low_gen i_low (
      .start_low (col_q[BLK_W-1:0]),
      .beat      (beat),
      .mask      (mask_q),
      .order     (order_q),
      .low_out   (low_addr)
   );

   if (HI_W > 0) begin : g_hi
      assign col_addr = {col_q[COL_W-1:BLK_W], low_addr};
   end else begin : g_nohi
      assign col_addr = low_addr;
   end

   assign addr_valid = active;
   assign burst_last = last;
   assign len_err    = err;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst,
   input logic             start,
   input logic [COL_W-1:0] col_addr,
   input logic             addr_valid,
   input logic             burst_last,
   input logic             len_err
);

   AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!addr_valid && !burst_last && !len_err)); // R1

   AST_LAST_ON_BEAT: assert property (@(posedge clk) disable iff (rst) burst_last |-> addr_valid); // R8

   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst) (burst_last && !start) |=> !addr_valid); // R8

   AST_MID_CONTINUES: assert property (@(posedge clk) disable iff (rst) (addr_valid && !burst_last) |=> addr_valid); // R9

   AST_HIGH_FIXED: assert property (@(posedge clk) disable iff (rst)
      (addr_valid && !burst_last) |=> (col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3]))); // R6

   AST_BEAT_MOVES: assert property (@(posedge clk) disable iff (rst)
      (addr_valid && !burst_last) |=> (col_addr != $past(col_addr))); // R4

   AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (rst) len_err |-> !addr_valid); // R10

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) i_chk (.*);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;

   localparam int COL_W = 10;

   logic             clk = 1'b0;
   logic             rst;
   logic             start;
   logic [COL_W-1:0] start_col;
   logic [3:0]       mode_word;
   logic [COL_W-1:0] col_addr;
   logic             addr_valid;
   logic             burst_last;
   logic             len_err;

   always #5 clk = ~clk;

   burst_col_seq #(.COL_W(COL_W), .MODE_W(4)) i_burst_col_seq (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .start_col  (start_col),
      .mode_word  (mode_word),
      .col_addr   (col_addr),
      .addr_valid (addr_valid),
      .burst_last (burst_last),
      .len_err    (len_err)
   );

   typedef struct packed {
      logic [COL_W-1:0] a;
      logic             l;
   } exp_t;

   exp_t q[$];
   int   vecs = 0;
   int   bad  = 0;
   int   cyc  = 0;
   bit   done = 0;

   task automatic check(input string req, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int len_of(input logic [2:0] code);
      case (code)
         3'b001:  return 2;
         3'b010:  return 4;
         3'b011:  return 8;
         default: return 0;
      endcase
   endfunction

   // expected address from R4 R5 R6
   function automatic logic [COL_W-1:0] model(input logic [COL_W-1:0] sc,
                                              input bit intlv, input int len, input int k);
      int lo, idx;
      lo  = int'(sc) % len;
      idx = intlv ? (lo ^ k) : ((lo + k) % len);
      return COL_W'((int'(sc) - lo) + idx);
   endfunction

   // driver: called at a falling edge, returns one falling edge later
   task automatic issue(input logic [COL_W-1:0] sc, input logic [3:0] mw, input bit push);
      int len;
      len = len_of(mw[2:0]);
      if (push) begin
         for (int k = 0; k < len; k++) begin
            exp_t e;
            e.a = model(sc, mw[3], len, k);
            e.l = (k == len - 1);
            q.push_back(e);
         end
      end
      start     = 1'b1;
      start_col = sc;
      mode_word = mw;
      @(negedge clk);
      start     = 1'b0;
      start_col = '0;
      mode_word = '0;
   endtask

   task automatic drain();
      repeat (10) @(negedge clk);
   endtask

   task automatic reserved_case(input logic [2:0] code);
      issue(10'h2C4, {1'b0, code}, 1'b0);
      check("R10 len_err raised", int'(len_err), 1);
      check("R10 no beat", int'(addr_valid), 0);
      @(negedge clk);
      check("R10 len_err one cycle", int'(len_err), 0);
      check("R10 no beat later", int'(addr_valid), 0);
   endtask

   // monitor: compare each beat with the scoreboard
   always @(negedge clk) begin
      if (!rst && addr_valid) begin
         if (q.size() == 0) begin
            vecs++;
            bad++;
            $display("FAIL R9 unexpected beat actual=%0h expected=none", col_addr);
         end else begin
            exp_t e;
            e = q.pop_front();
            check("R3 R4 R5 R6 R7 beat address", int'(col_addr), int'(e.a));
            check("R8 last flag", int'(burst_last), int'(e.l));
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end

   initial begin
      rst       = 1'b1;
      start     = 1'b0;
      start_col = '0;
      mode_word = '0;
      repeat (3) @(negedge clk);
      check("R1 valid in reset", int'(addr_valid), 0);
      check("R1 last in reset", int'(burst_last), 0);
      check("R1 err in reset", int'(len_err), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 idle after reset", int'(addr_valid), 0);

      // R4 sequential length 8 start 5
      issue(10'h2A5, 4'b0011, 1'b1);
      drain();
      check("R3 idle after burst", int'(addr_valid), 0);

      // R5 interleaved length 8 start 6
      issue(10'h1B6, 4'b1011, 1'b1);
      drain();

      // R2 length 4, both orders, R6 with bit 2 fixed
      issue(10'h0F2, 4'b0010, 1'b1);
      drain();
      issue(10'h3CF, 4'b1010, 1'b1);
      drain();

      // R7 length 2
      issue(10'h155, 4'b0001, 1'b1);
      drain();
      issue(10'h155, 4'b1001, 1'b1);
      drain();
      issue(10'h2AA, 4'b1001, 1'b1);
      drain();

      // R10 reserved codes
      reserved_case(3'b000);
      reserved_case(3'b111);
      reserved_case(3'b100);

      // R9 start in mid burst is ignored
      issue(10'h300, 4'b0011, 1'b1);
      repeat (2) @(negedge clk);
      issue(10'h0FF, 4'b1010, 1'b0);
      drain();

      // R9 start on last beat runs back to back
      issue(10'h246, 4'b0010, 1'b1);
      repeat (3) @(negedge clk);
      check("R9 on last beat", int'(burst_last), 1);
      issue(10'h1C1, 4'b1001, 1'b1);
      drain();

      check("R9 scoreboard empty", q.size(), 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

endmodule